// File: doc/BRIEF.md
# Master-Mode Audio Clock Generator

This block produces the serial bit clock and the left/right frame clock of an audio serial port that runs as clock master. Everything lives in the master-clock domain. Each clock is delivered two ways: as a registered level output, and as a one-cycle enable pulse that marks the start of a bit period or of a frame. Downstream logic uses the pulses as clock enables, so no gated or derived clock is ever built.

A 3-bit rate code sets how many master-clock cycles make one sample frame. A mode input chooses between the ordinary framed formats and a time-multiplexed mode. In the time-multiplexed mode one bit is sent per master-clock cycle, so that eight channel slots fit in a frame. A word-length input is compared against the slot budget of that mode. If a slot cannot hold the word, or if the rate code is one of the two unused codes, a configuration-error flag is raised.

Rate and mode changes are held back until the current frame has run its full length. The frame counter and the bit-clock phase then restart together, so the two clocks never lose alignment.

Top module: `audio_clkgen`

## Requirements
- R1: Rate codes 0,1,2,3,4,5 give frames of 128, 192, 256, 384, 512 and 768 master-clock cycles. `frameTick` is high in the first cycle of every frame, so the distance between two pulses is the frame length.
- R2: In framed mode (`dspMode`=0) the bit period is 2 master cycles for codes 0 and 1, and 4 master cycles for codes 2 to 5. `bitTick` is high when the in-frame cycle index k is a multiple of the period.
- R3: In time-multiplexed mode (`dspMode`=1) `bitTick` is high in every cycle and `bitClk` is held at 1.
- R4: `frameClk` is 1 for in-frame indices k below half the frame length (the left half) and 0 for the rest.
- R5: `cfgErr` is 1 one cycle after the inputs show `dspMode`=1 with code 0 and `wordLen` above 16, or `dspMode`=1 with code 1 and `wordLen` above 24. A word length exactly at the limit gives 0.
- R6: Codes 6 and 7 hold `bitClk`, `frameClk`, `bitTick` and `frameTick` at 0 and set `cfgErr` one cycle later.
- R7: `bitTick` is high in every cycle in which `frameTick` is high. For periods of 2 or more, `bitClk` is 1 in the first half of each bit period.
- R8: A new rate or mode is taken up only in the cycle after the last cycle of the running frame. When the running code is reserved, the new setting is taken up at the next edge.
- R9: While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rateCode | input | 3 | Master-clock-to-sample-rate code |
| dspMode | input | 1 | 1 selects time-multiplexed mode |
| wordLen | input | 6 | Sample word length in bits |
| bitClk | output | 1 | Registered bit-clock level |
| bitTick | output | 1 | One-cycle pulse at each bit-period start |
| frameClk | output | 1 | Registered frame clock, 1 for the left half |
| frameTick | output | 1 | One-cycle pulse at each frame start |
| cfgErr | output | 1 | Illegal rate, mode or word-length combination |

## Verification
The end of a frame and a new configuration request can land in the same cycle, and which way that cycle resolves decides the length of the next frame. The bench sets a new code exactly in the frame's last cycle and expects a frame-start pulse on the next cycle, followed by a frame of the new length. It then sets a code in the first cycle of a frame and expects the old length to be kept for one more whole frame. A third case starts from a reserved code and expects the new setting to begin a frame on the very next edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int RATE_W = 3;
  localparam int CNT_W  = 10;
  localparam int DIV_W  = 3;

  localparam logic [RATE_W-1:0] RATE_IDLE = 3'b111;

  typedef struct packed {
    logic load;   // restart counter with the next configuration
    logic quiet;  // next configuration is reserved: hold clocks low
  } strobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    ratioOf = CNT_W'(128);
      3'd1:    ratioOf = CNT_W'(192);
      3'd2:    ratioOf = CNT_W'(256);
      3'd3:    ratioOf = CNT_W'(384);
      3'd4:    ratioOf = CNT_W'(512);
      3'd5:    ratioOf = CNT_W'(768);
      default: ratioOf = '0;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] divOf(input logic [RATE_W-1:0] code,
                                             input logic dsp);
    if (dsp)
      divOf = DIV_W'(1);
    else if (code <= 3'd1)
      divOf = DIV_W'(2);
    else
      divOf = DIV_W'(4);
  endfunction

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int WL_W = 6
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              dspMode,
  input  logic [WL_W-1:0]   wordLen,
  input  logic              lastCycle,
  output strobe_t           strobe,
  output logic [CNT_W-1:0]  curRatio,
  output logic [CNT_W-1:0]  nextRatio,
  output logic [DIV_W-1:0]  nextDiv,
  output logic              cfgErr
);

  localparam logic [WL_W-1:0] WL_LIM_128 = WL_W'(16);
  localparam logic [WL_W-1:0] WL_LIM_192 = WL_W'(24);

  logic [RATE_W-1:0] activeCode;
  logic              activeDsp;
  logic [RATE_W-1:0] nextCode;
  logic              nextDsp;
  logic              idle;
  logic              errNow;

  assign curRatio = ratioOf(activeCode);
  assign idle     = (curRatio == '0);

  always_comb begin
    strobe.load  = idle | lastCycle;
    nextCode     = strobe.load ? rateCode : activeCode;
    nextDsp      = strobe.load ? dspMode  : activeDsp;
    nextRatio    = ratioOf(nextCode);
    nextDiv      = divOf(nextCode, nextDsp);
    strobe.quiet = (nextRatio == '0);
  end

  // Word-length budget of the multiplexed slots
  always_comb begin
    errNow = (ratioOf(rateCode) == '0);
    if (dspMode && rateCode == 3'd0 && wordLen > WL_LIM_128) errNow = 1'b1;
    if (dspMode && rateCode == 3'd1 && wordLen > WL_LIM_192) errNow = 1'b1;
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= RATE_IDLE;
      activeDsp  <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      activeCode <= nextCode;
      activeDsp  <= nextDsp;
      cfgErr     <= errNow;
    end
  end

  // R8: configuration is frozen between frame boundaries
  a_r8_hold_cfg: assert property (@(posedge mclk) disable iff (!rstN)
    !strobe.load |=> ($stable(activeCode) && $stable(activeDsp)));

  // R5: oversized word in the 128 and 192 multiplexed modes is flagged
  a_r5_wl_128: assert property (@(posedge mclk) disable iff (!rstN)
    (dspMode && rateCode == 3'd0 && wordLen > WL_LIM_128) |=> cfgErr);
  a_r5_wl_192: assert property (@(posedge mclk) disable iff (!rstN)
    (dspMode && rateCode == 3'd1 && wordLen > WL_LIM_192) |=> cfgErr);

endmodule

// File: rtl/aclk_dp.sv
module aclk_dp
  import aclk_pkg::*;
(
  input  logic             mclk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] curRatio,
  input  logic [CNT_W-1:0] nextRatio,
  input  logic [DIV_W-1:0] nextDiv,
  output logic             lastCycle,
  output logic             bitClk,
  output logic             bitTick,
  output logic             frameClk,
  output logic             frameTick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [DIV_W-1:0] phase;

  assign lastCycle = (curRatio != '0) && (cnt == curRatio - CNT_W'(1));
  assign cntNext   = strobe.load ? '0 : cnt + CNT_W'(1);
  assign phase     = cntNext[DIV_W-1:0] & (nextDiv - DIV_W'(1));

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      bitClk    <= 1'b0;
      bitTick   <= 1'b0;
      frameClk  <= 1'b0;
      frameTick <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobe.quiet) begin
        bitClk    <= 1'b0;
        bitTick   <= 1'b0;
        frameClk  <= 1'b0;
        frameTick <= 1'b0;
      end else begin
        frameClk  <= (cntNext < (nextRatio >> 1));
        frameTick <= (cntNext == '0);
        bitTick   <= (phase == '0);
        bitClk    <= (nextDiv == DIV_W'(1)) ? 1'b1 : (phase < (nextDiv >> 1));
      end
    end
  end

  // R7: a frame never starts in the middle of a bit period
  a_r7_aligned: assert property (@(posedge mclk) disable iff (!rstN)
    frameTick |-> bitTick);

  // R4: each frame opens with the left half
  a_r4_left_first: assert property (@(posedge mclk) disable iff (!rstN)
    frameTick |-> frameClk);

  // R1: frames are far longer than one cycle, so frame pulses never repeat back to back
  a_r1_single_pulse: assert property (@(posedge mclk) disable iff (!rstN)
    frameTick |=> !frameTick);

  // R6: a reserved configuration silences every clock output
  a_r6_quiet: assert property (@(posedge mclk) disable iff (!rstN)
    strobe.quiet |=> (!bitClk && !bitTick && !frameClk && !frameTick));

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int WL_W = 6
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              dspMode,
  input  logic [WL_W-1:0]   wordLen,
  output logic              bitClk,
  output logic              bitTick,
  output logic              frameClk,
  output logic              frameTick,
  output logic              cfgErr
);

  strobe_t          strobe;
  logic [CNT_W-1:0] curRatio;
  logic [CNT_W-1:0] nextRatio;
  logic [DIV_W-1:0] nextDiv;
  logic             lastCycle;

  aclk_ctrl #(.WL_W(WL_W)) u_ctrl (
    .mclk      (mclk),
    .rstN      (rstN),
    .rateCode  (rateCode),
    .dspMode   (dspMode),
    .wordLen   (wordLen),
    .lastCycle (lastCycle),
    .strobe    (strobe),
    .curRatio  (curRatio),
    .nextRatio (nextRatio),
    .nextDiv   (nextDiv),
    .cfgErr    (cfgErr)
  );

  aclk_dp u_dp (
    .mclk      (mclk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curRatio  (curRatio),
    .nextRatio (nextRatio),
    .nextDiv   (nextDiv),
    .lastCycle (lastCycle),
    .bitClk    (bitClk),
    .bitTick   (bitTick),
    .frameClk  (frameClk),
    .frameTick (frameTick)
  );

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;

  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rateCode = 3'd2;
  logic       dspMode = 1'b0;
  logic [5:0] wordLen = 6'd16;
  logic       bitClk, bitTick, frameClk, frameTick, cfgErr;

  always #2 mclk = ~mclk;  // 250 MHz

  audio_clkgen i_audio_clkgen (
    .mclk(mclk), .rstN(rstN), .rateCode(rateCode), .dspMode(dspMode),
    .wordLen(wordLen), .bitClk(bitClk), .bitTick(bitTick),
    .frameClk(frameClk), .frameTick(frameTick), .cfgErr(cfgErr)
  );

  localparam int NV = 12;
  localparam int V_RATE  [NV] = '{0, 1, 2, 3, 4, 5, 0, 0, 1, 1, 2, 5};
  localparam int V_DSP   [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_WL    [NV] = '{16, 24, 24, 32, 16, 24, 16, 24, 24, 32, 32, 32};
  localparam int V_RATIO [NV] = '{128, 192, 256, 384, 512, 768, 128, 128, 192, 192, 256, 768};
  localparam int V_DIV   [NV] = '{2, 2, 4, 4, 4, 4, 1, 1, 1, 1, 1, 1};
  localparam int V_ERR   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0};

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge mclk);
  endtask

  task automatic setCfg(input int r, input int d, input int w);
    rateCode = 3'(r);
    dspMode  = d[0];
    wordLen  = 6'(w);
  endtask

  // Steps until the next frame-start pulse; returns steps taken
  task automatic frameLen(output int len);
    len = 0;
    do begin
      step();
      len++;
    end while (!frameTick && len < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int len;
    // R9: reset state
    repeat (3) step();
    check({bitClk, bitTick, frameClk, frameTick, cfgErr} == 5'b0,
          "R9 outputs in reset", {bitClk, bitTick, frameClk, frameTick, cfgErr}, 0);
    setCfg(V_RATE[0], V_DSP[0], V_WL[0]);
    rstN = 1'b1;

    // Vector walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      int badF, badB, badT;
      int ratio, dv;
      badF = 0; badB = 0; badT = 0;
      ratio = V_RATIO[v];
      dv = V_DIV[v];
      setCfg(V_RATE[v], V_DSP[v], V_WL[v]);
      frameLen(len);
      check(cfgErr == V_ERR[v][0], $sformatf("R5 cfgErr vector %0d", v), cfgErr, V_ERR[v]);
      for (int k = 0; k <= ratio; k++) begin
        if (k == ratio) begin
          check(frameTick == 1'b1, $sformatf("R1 frame length vector %0d", v), frameTick, 1);
        end else begin
          bit expF, expT, expBT, expBC;
          expF  = (k < ratio / 2);
          expT  = (k == 0);
          expBT = ((k % dv) == 0);
          expBC = (dv == 1) ? 1'b1 : ((k % dv) < dv / 2);
          if (frameClk != expF) badF++;
          if (frameTick != expT) badT++;
          if (bitTick != expBT || bitClk != expBC) badB++;
          step();
        end
      end
      check(badF == 0, $sformatf("R4 frame clock vector %0d", v), badF, 0);
      check(badT == 0, $sformatf("R1 frame pulse vector %0d", v), badT, 0);
      check(badB == 0, $sformatf("R2 R3 R7 bit clock vector %0d", v), badB, 0);
    end

    // R8: change in the middle of a frame waits for its end
    setCfg(2, 0, 16);
    frameLen(len);
    frameLen(len);
    check(len == 256, "R8 settle 256 frame", len, 256);
    repeat (50) step();
    setCfg(0, 0, 16);
    frameLen(len);
    check(len == 206, "R8 mid-frame change deferred", len, 206);
    frameLen(len);
    check(len == 128, "R8 new frame length after change", len, 128);

    // R8: change in the last cycle of a frame is taken at once
    repeat (127) step();
    setCfg(1, 0, 24);
    step();
    check(frameTick == 1'b1, "R8 change at last cycle restarts", frameTick, 1);
    frameLen(len);
    check(len == 192, "R8 frame after boundary change", len, 192);

    // R8: change in the first cycle keeps the old length one more frame
    setCfg(2, 0, 24);
    frameLen(len);
    check(len == 192, "R8 change at first cycle deferred", len, 192);
    frameLen(len);
    check(len == 256, "R8 next frame uses new code", len, 256);

    // R6: reserved code silences the clocks and flags an error
    setCfg(6, 0, 16);
    repeat (260) step();
    begin
      int noisy;
      noisy = 0;
      for (int i = 0; i < 10; i++) begin
        if (bitClk || bitTick || frameClk || frameTick) noisy++;
        step();
      end
      check(noisy == 0, "R6 clocks quiet on code 6", noisy, 0);
    end
    check(cfgErr == 1'b1, "R6 cfgErr on code 6", cfgErr, 1);
    setCfg(7, 1, 16);
    step();
    step();
    check(cfgErr == 1'b1, "R6 cfgErr on code 7", cfgErr, 1);
    check(frameClk == 1'b0 && bitClk == 1'b0, "R6 clocks low on code 7",
          {frameClk, bitClk}, 0);

    // R8: leaving a reserved code starts a frame on the next edge
    setCfg(3, 0, 24);
    step();
    check(frameTick == 1'b1, "R8 restart from reserved", frameTick, 1);
    check(cfgErr == 1'b0, "R5 cfgErr clears on legal code", cfgErr, 0);
    frameLen(len);
    check(len == 384, "R1 frame length after reserved", len, 384);

    // R9: reset in mid-frame clears outputs
    repeat (10) step();
    rstN = 1'b0;
    step();
    check({bitClk, bitTick, frameClk, frameTick, cfgErr} == 5'b0,
          "R9 outputs after mid-frame reset", {bitClk, bitTick, frameClk, frameTick, cfgErr}, 0);
    rstN = 1'b1;
    step();
    check(frameTick == 1'b1, "R9 first frame after reset", frameTick, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule